// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between a UART and an infrared or opto-isolated line. It translates between ordinary NRZ bit timing and SIR pulse timing. All timing comes from a one-cycle tick enable at sixteen times the baud rate. The UART supplies the phase of the current bit cell for each direction as a 4-bit tick index, counted 0 to 15 from the first tick of the cell. Framing, parity and buffering stay in the surrounding UART.

On the transmit side, the NRZ level is sampled at the first tick of each cell. In SIR mode, a zero becomes a low pulse exactly three ticks long and a one leaves the line high. With SIR mode off, the NRZ level goes straight to the line.

On the receive side, one decided bit is produced per cell. In normal mode the bit is a majority vote of three mid-cell samples. In SIR mode the line is active high and is sampled once, early in the cell, at the middle of a three-tick pulse. The bit reads as zero only when that high level has already been present for two ticks, so very short glitches are rejected.

The received bits leave as a valid-only stream. A bit is offered for exactly one clock cycle and there is no ready input, because a live line cannot be paused. The consumer must take the bit in the strobe cycle. The transmit input and the mode pin are plain levels.

Top module: `irsir_codec`

## Requirements
- R1: While reset is asserted, `tx_line_o` is high with SIR mode on, and `rx_bit_valid_o` is low.
- R2: With `sir_mode_i` low, `tx_line_o` equals `tx_nrz_i` in the same cycle.
- R3: In SIR mode, when `tx_nrz_i` is 0 at the tick with `tx_phase_i` = 0, `tx_line_o` goes low in the next cycle. It stays low until the cycle after the tick with phase 3, whatever `tx_nrz_i` does in the meantime.
- R4: In SIR mode, when `tx_nrz_i` is 1 at the phase-0 tick, `tx_line_o` stays high for the whole cell.
- R5: In normal mode, one cycle after the tick with `rx_phase_i` = 8, `rx_bit_o` carries the majority of `rx_line_i` as sampled at the ticks with phases 6, 7 and 8.
- R6: In SIR mode, one cycle after the tick with `rx_phase_i` = 1, `rx_bit_o` is 0 when `rx_line_i` (high = pulse) was high at the phase-0 tick and at the phase-1 tick; otherwise it is 1.
- R7: In SIR mode, a pulse that is high at the phase-1 tick but was low at the tick before it is rejected, and the bit reads 1.
- R8: In SIR mode, a pulse that has already ended by the phase-1 tick reads as 1.
- R9: `rx_bit_valid_o` is high for exactly one cycle per cell: the cycle after the decision tick of the current mode.
- R10: Turning SIR mode off ends a pulse at once and cancels it, so turning the mode back on mid-cell leaves the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle enable at 16x baud |
| sir_mode_i | input | 1 | 1 = SIR pulse timing, 0 = plain NRZ |
| tx_phase_i | input | 4 | Tick index of the transmit bit cell |
| tx_nrz_i | input | 1 | NRZ level from the UART transmitter |
| tx_line_o | output | 1 | Line output (low pulse = zero in SIR mode) |
| rx_phase_i | input | 4 | Tick index of the receive bit cell |
| rx_line_i | input | 1 | Line input (high pulse = zero in SIR mode) |
| rx_bit_valid_o | output | 1 | One-cycle strobe for a decided bit |
| rx_bit_o | output | 1 | Decided receive bit |

## Verification
The transmit line changes one clock after the tick that triggers it. A zero pulse is therefore low from the cycle after the phase-0 tick through the cycle of the phase-3 tick, and it is high again one cycle later. In normal mode the line follows the NRZ input in the same cycle. The receive strobe rises one clock after the deciding tick: phase 8 in normal mode, phase 1 in SIR mode. The bench drives all inputs on the falling edge and compares the outputs 1 ns later. It checks the transmit line and the strobe at every cycle against a schedule derived from the tick count, and a monitor matches each strobe against the bit expected for that cell from the line pattern.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  // Ticks per bit cell is 2**PHASE_W.
  localparam int unsigned PHASE_W = 4;
  typedef logic [PHASE_W-1:0] phase_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/irsir_tx_shaper.sv
module irsir_tx_shaper
  import irsir_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  logic   sir_i,
  input  logic   nrz_i,
  input  phase_t phase_i,
  output logic   line_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);

  logic [CNT_W-1:0] left_q;
  logic             cell_start;

  assign cell_start = tick_i && (phase_i == '0);

  // Ticks remaining in the current pulse; cleared whenever SIR mode is off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (!sir_i) begin
      left_q <= '0;
    end else if (tick_i) begin
      if (cell_start && !nrz_i) left_q <= CNT_W'(PULSE_TICKS);
      else if (left_q != '0)    left_q <= left_q - 1'b1;
    end
  end

  assign line_o = sir_i ? (left_q == '0) : nrz_i;

  a_r3_zero_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sir_i && cell_start && !nrz_i) |=> (!line_o || !sir_i));

  a_r4_one_leaves_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sir_i && cell_start && nrz_i && left_q == '0) |=> (line_o || !sir_i));
endmodule

// File: rtl/irsir_rx_runlen.sv
module irsir_rx_runlen #(
  parameter int unsigned SAT   = 2,
  parameter int unsigned RUN_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             line_i,
  output logic [RUN_W-1:0] run_o
);
  // Counts consecutive ticks that saw the line high, saturating at SAT.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o <= '0;
    end else if (tick_i) begin
      if (!line_i)                    run_o <= '0;
      else if (run_o != RUN_W'(SAT))  run_o <= run_o + 1'b1;
    end
  end

  a_r7_run_clears_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !line_i) |=> (run_o == '0));
endmodule

// File: rtl/irsir_rx_sampler.sv
module irsir_rx_sampler
  import irsir_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 2,
  parameter int unsigned RUN_W      = 2,
  parameter int unsigned IR_PH      = 1,
  parameter int unsigned MAJ_PH     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sir_i,
  input  logic             line_i,
  input  phase_t           phase_i,
  input  logic [RUN_W-1:0] run_i,
  output logic             bit_valid_o,
  output logic             bit_o
);
  localparam int unsigned EARLY_TAPS = 2;

  logic [EARLY_TAPS-1:0] early_q;
  logic                  at_ir;
  logic                  at_vote;
  logic                  qualified;

  assign at_ir     = tick_i && sir_i && (phase_i == phase_t'(IR_PH));
  assign at_vote   = tick_i && !sir_i && (phase_i == phase_t'(MAJ_PH + EARLY_TAPS));
  assign qualified = line_i && (run_i >= RUN_W'(QUAL_TICKS - 1));

  // Early majority taps, one register per tick position before the vote.
  for (genvar g = 0; g < EARLY_TAPS; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) early_q[g] <= 1'b1;
      else if (tick_i && !sir_i && (phase_i == phase_t'(MAJ_PH + g)))
        early_q[g] <= line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b1;
    end else begin
      bit_valid_o <= at_ir || at_vote;
      if (at_vote)    bit_o <= maj3(early_q[0], early_q[1], line_i);
      else if (at_ir) bit_o <= !qualified;
    end
  end

  a_r9_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> $past(tick_i));

  a_r8_low_line_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ir && !line_i) |=> (bit_valid_o && bit_o));

  a_r7_unqualified_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ir && run_i == '0) |=> bit_o);

  a_r5_all_high_votes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (at_vote && line_i && early_q == '1) |=> (bit_valid_o && bit_o));
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 3,
  parameter int unsigned QUAL_TICKS  = 2,
  parameter int unsigned IR_PH       = 1,
  parameter int unsigned MAJ_PH      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick16_i,
  input  logic               sir_mode_i,
  input  logic [PHASE_W-1:0] tx_phase_i,
  input  logic               tx_nrz_i,
  output logic               tx_line_o,
  input  logic [PHASE_W-1:0] rx_phase_i,
  input  logic               rx_line_i,
  output logic               rx_bit_valid_o,
  output logic               rx_bit_o
);
  localparam int unsigned RUN_W = $clog2(QUAL_TICKS + 1);

  logic [RUN_W-1:0] run;

  irsir_tx_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick16_i),
    .sir_i   (sir_mode_i),
    .nrz_i   (tx_nrz_i),
    .phase_i (tx_phase_i),
    .line_o  (tx_line_o)
  );

  irsir_rx_runlen #(.SAT(QUAL_TICKS), .RUN_W(RUN_W)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick16_i),
    .line_i (rx_line_i),
    .run_o  (run)
  );

  irsir_rx_sampler #(
    .QUAL_TICKS (QUAL_TICKS),
    .RUN_W      (RUN_W),
    .IR_PH      (IR_PH),
    .MAJ_PH     (MAJ_PH)
  ) u_smp (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick16_i),
    .sir_i       (sir_mode_i),
    .line_i      (rx_line_i),
    .phase_i     (rx_phase_i),
    .run_i       (run),
    .bit_valid_o (rx_bit_valid_o),
    .bit_o       (rx_bit_o)
  );
endmodule

// File: tb/irsir_codec_tb_top.sv
module irsir_codec_tb_top;
  import irsir_pkg::*;

  localparam int TICK_DIV   = 4;
  localparam int CELL_STEPS = 16 * TICK_DIV;
  localparam int PULSE      = 3;

  logic   clk = 1'b0;
  logic   rst_n = 1'b0;
  logic   tick = 1'b0;
  logic   sir = 1'b1;
  logic   tx_nrz = 1'b1;
  logic   rx_line = 1'b0;
  phase_t phase = '0;
  logic   tx_line, vld, rbit;

  int    n_checks = 0;
  int    n_fail   = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  irsir_codec dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick16_i       (tick),
    .sir_mode_i     (sir),
    .tx_phase_i     (phase),
    .tx_nrz_i       (tx_nrz),
    .tx_line_o      (tx_line),
    .rx_phase_i     (phase),
    .rx_line_i      (rx_line),
    .rx_bit_valid_o (vld),
    .rx_bit_o       (rbit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: each strobe pops the bit the driver predicted for that cell.
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R9 strobe with no cell pending actual=1 expected=0");
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rbit, e);
      end
    end
  end

  // Driver: one full bit cell in the given mode with a per-tick RX pattern.
  task automatic run_cell(input logic irda, input logic nrz, input logic [15:0] pat,
                          input string tag);
    logic e_bit, e_tx, e_v;
    e_bit = irda ? !(pat[0] && pat[1]) : maj3(pat[6], pat[7], pat[8]);
    exp_q.push_back(e_bit);
    tag_q.push_back(tag);
    for (int j = 0; j < CELL_STEPS; j++) begin
      @(negedge clk);
      tick    = (j % TICK_DIV) == 0;
      phase   = phase_t'(j / TICK_DIV);
      tx_nrz  = nrz;
      rx_line = pat[j / TICK_DIV];
      sir     = irda;
      #1;
      e_tx = irda ? !(!nrz && j >= 1 && j <= PULSE * TICK_DIV) : nrz;
      check(irda ? (nrz ? "R4" : "R3") : "R2", tx_line, e_tx);
      e_v = (j == (irda ? 1 : 8) * TICK_DIV + 1);
      check("R9", vld, e_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", tx_line, 1'b1);
    check("R1", vld, 1'b0);
    rst_n = 1'b1;

    // Normal mode: majority of phases 6, 7, 8 (R5), passthrough TX (R2)
    run_cell(1'b0, 1'b0, 16'h01C0, "R5");
    run_cell(1'b0, 1'b1, 16'h0140, "R5");
    run_cell(1'b0, 1'b0, 16'h0080, "R5");
    run_cell(1'b0, 1'b1, 16'hFE3F, "R5");
    run_cell(1'b0, 1'b1, 16'h0100, "R5");

    // SIR mode: qualified pulse (R6), glitch (R7), ended pulse (R8)
    run_cell(1'b1, 1'b0, 16'h0007, "R6");
    run_cell(1'b1, 1'b1, 16'h0000, "R6");
    run_cell(1'b1, 1'b0, 16'h8002, "R7");
    run_cell(1'b1, 1'b0, 16'h0001, "R8");
    run_cell(1'b1, 1'b1, 16'h0003, "R6");
    run_cell(1'b1, 1'b0, 16'hFFF8, "R8");
    run_cell(1'b0, 1'b0, 16'hFFFF, "R5");
    run_cell(1'b1, 1'b0, 16'hFFFF, "R6");

    // R10: mode dropped mid-pulse, NRZ changed mid-cell, mode restored mid-cell
    exp_q.push_back(1'b1);
    tag_q.push_back("R6");
    for (int j = 0; j < 4 * TICK_DIV; j++) begin
      @(negedge clk);
      tick    = (j % TICK_DIV) == 0;
      phase   = phase_t'(j / TICK_DIV);
      rx_line = 1'b0;
      sir     = !(j >= 6 && j < 10);
      tx_nrz  = (j < 4 || j == 8 || j == 9) ? 1'b0 : 1'b1;
      #1;
      if (j >= 1 && j < 6)       check("R3", tx_line, 1'b0);
      else if (j >= 6 && j < 10) check("R10", tx_line, tx_nrz);
      else if (j >= 10)          check("R10", tx_line, 1'b1);
    end
    run_cell(1'b1, 1'b1, 16'h0006, "R7");

    @(negedge clk);
    tick = 1'b0;
    repeat (4) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing strobes actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule